// File: doc/BRIEF.md
# Output Rounding, Limiting and Format Stage

This block sits at the output side of a fixed-coefficient half-band filter. It takes the filter's wide signed result, carried with four fraction bits below the output LSB and two headroom bits above the output sign, and turns it into a 16-bit output word. A 3-bit rounding code sets both the rounding position and the active bus width. A narrow-width select turns one of those codes into an 8-bit mode. The stage rounds by half a kept LSB and then clips to full-scale limits so the output never wraps. It then presents the value as two's complement, unsigned or inverted offset binary.

The stage also produces a per-bit driver-enable mask. Bits below the kept LSB are released so that the pads can serve as control inputs. An active-high disable input removes every enable at once, without waiting for a clock. A half-gain control applies the -6 dB interpolation scaling, with its own tighter limits. The same control set converts the 12-bit input word from unsigned to two's complement before it enters the filter.

A load enable strobes the output register, so a decimating core can update the output on alternate cycles.

Top module: `oflt_top`

## Requirements
- R1: Rounding code c (0..7) keeps the top 16-c bits. `drv_en[15:c]` are ones and all lower enables are zero. Released `dout` bits read zero.
- R2: With code 4 and `narrow` high, only 8 bits are kept (`drv_en` = 16'hFF00). For every other code `narrow` has no effect.
- R3: Rounding adds half of the kept LSB weight to the result and then discards everything below the kept LSB. An exact half therefore rounds up, toward positive.
- R4: In unity-gain mode the rounded value is clipped to +16'h7FF0 and -16'h7FF0 (16'h8010). Clipping happens after rounding, so a value that rounding pushes past a limit is clipped too.
- R5: With `half_gain` high, the result is first shifted right by one bit, arithmetically, and then limited to +16'h3FF8 and -16'h3FF8 (16'hC008). Output bits 15 and 14 are then always equal.
- R6: `tco` high gives two's complement. `tco` low with `uns_io` high and a nonzero code gives unsigned, which is the value plus 16'h8000 (or plus 16'h4000 in half-gain mode). Otherwise the output is inverted offset binary, the bitwise complement of the unsigned word. Released bits are zero in every format.
- R7: `oe_n` high forces `drv_en` to all zeros at once, without a clock edge, and leaves `dout` unchanged.
- R8: A result presented with `ld_en` high appears on `dout` and `drv_en` after the next rising edge. With `ld_en` low both hold their value.
- R9: `din_tc` equals `din` with bit 11 inverted when `uns_io` is high and the code is nonzero. Otherwise `din_tc` equals `din`. The path has no register.
- R10: During reset, and until a load, `dout` and `drv_en` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Output register load enable |
| res | input | 22 | Signed filter result, 4 fraction bits below the output LSB |
| rnd | input | 3 | Rounding code / active width select |
| narrow | input | 1 | Turns code 4 into an 8-bit width |
| uns_io | input | 1 | Unsigned input and output data when the code is nonzero |
| tco | input | 1 | Two's complement output when high |
| half_gain | input | 1 | -6 dB interpolation scaling and limits |
| oe_n | input | 1 | Active-high disable of all drivers, asynchronous |
| din | input | 12 | Raw input data word |
| din_tc | output | 12 | Input word converted to two's complement |
| dout | output | 16 | Rounded, limited and formatted output word |
| drv_en | output | 16 | Per-bit output driver enable |

## Verification
The bench aims at rounding ties at several widths, including the 8-bit mode and a code where `narrow` must be ignored. A design that truncates, or that rounds a tie toward zero, would return a value one kept LSB low on those ties. It drives values that only cross a limit after rounding; a design that clips before rounding would emit 16'h7FF1. It checks the half-gain limits and the offset shift for unsigned output, which a design reusing the unity-gain constants would miss. It also drops `oe_n` between clock edges, where a registered enable would be late.

// File: rtl/oflt_pkg.sv
package oflt_pkg;

  typedef enum logic [1:0] {
    FMT_TWOS  = 2'd0,
    FMT_UNS   = 2'd1,
    FMT_INVOB = 2'd2
  } fmt_e;

  function automatic fmt_e pick_fmt(input logic tco, input logic uns_io,
                                    input logic [2:0] rnd);
    if (tco)                       return FMT_TWOS;
    else if (uns_io && rnd != '0)  return FMT_UNS;
    else                           return FMT_INVOB;
  endfunction

endpackage

// File: rtl/oflt_width_dec.sv
module oflt_width_dec #(
  parameter int OUT_W    = 16,
  parameter int NARROW_W = 8,
  parameter int DROP_W   = 4
) (
  input  logic [2:0]        rnd,
  input  logic              narrow,
  output logic [DROP_W-1:0] drop,
  output logic [OUT_W-1:0]  mask
);
  localparam int NARROW_DROP = OUT_W - NARROW_W;
  localparam logic [2:0] NARROW_CODE = 3'd4;

  always_comb begin
    if (rnd == NARROW_CODE && narrow) drop = DROP_W'(NARROW_DROP);
    else                              drop = DROP_W'(rnd);
  end

  for (genvar gi = 0; gi < OUT_W; gi++) begin : g_mask
    assign mask[gi] = (DROP_W'(gi) >= drop);
  end
endmodule

// File: rtl/oflt_round.sv
module oflt_round #(
  parameter int ACC_W  = 22,
  parameter int FRAC   = 4,
  parameter int DROP_W = 4,
  localparam int RV_W  = ACC_W - FRAC + 1
) (
  input  logic signed [ACC_W-1:0] res,
  input  logic                    half_gain,
  input  logic [DROP_W-1:0]       drop,
  output logic signed [RV_W-1:0]  rval
);
  localparam int SH_W = $clog2(ACC_W + 1) + 1;

  logic signed [ACC_W-1:0] scaled;
  logic signed [ACC_W:0]   ext;
  logic signed [ACC_W:0]   bump;
  logic signed [ACC_W:0]   sum;
  logic signed [ACC_W:0]   shr;
  logic signed [RV_W-1:0]  coarse;
  logic [SH_W-1:0]         cut;

  always_comb begin
    scaled = half_gain ? (res >>> 1) : res;
    ext    = {scaled[ACC_W-1], scaled};
    cut    = SH_W'(FRAC) + SH_W'(drop);
    bump   = (ACC_W+1)'(1) <<< (cut - SH_W'(1));
    sum    = ext + bump;
    shr    = sum >>> cut;
    coarse = shr[RV_W-1:0];
    rval   = coarse <<< drop;
  end
endmodule

// File: rtl/oflt_limit.sv
module oflt_limit #(
  parameter int          RV_W     = 19,
  parameter int          OUT_W    = 16,
  parameter logic [15:0] LIM_FULL = 16'h7FF0,
  parameter logic [15:0] LIM_HALF = 16'h3FF8
) (
  input  logic signed [RV_W-1:0]  rval,
  input  logic                    half_gain,
  output logic signed [OUT_W-1:0] lim
);
  logic signed [RV_W-1:0] hi;
  logic signed [RV_W-1:0] lo;

  always_comb begin
    hi = half_gain ? $signed({{(RV_W-16){1'b0}}, LIM_HALF})
                   : $signed({{(RV_W-16){1'b0}}, LIM_FULL});
    lo = -hi;
    if (rval > hi)      lim = hi[OUT_W-1:0];
    else if (rval < lo) lim = lo[OUT_W-1:0];
    else                lim = rval[OUT_W-1:0];
  end
endmodule

// File: rtl/oflt_format.sv
module oflt_format #(
  parameter int OUT_W = 16
) (
  input  logic signed [OUT_W-1:0] lim,
  input  oflt_pkg::fmt_e          fmt,
  input  logic                    half_gain,
  input  logic [OUT_W-1:0]        mask,
  output logic [OUT_W-1:0]        word
);
  import oflt_pkg::*;

  localparam logic [OUT_W-1:0] OFF_FULL = OUT_W'(1) << (OUT_W - 1);
  localparam logic [OUT_W-1:0] OFF_HALF = OUT_W'(1) << (OUT_W - 2);

  logic [OUT_W-1:0] ubin;
  logic [OUT_W-1:0] pre;

  always_comb begin
    ubin = lim + (half_gain ? OFF_HALF : OFF_FULL);
    unique case (fmt)
      FMT_TWOS: pre = lim;
      FMT_UNS:  pre = ubin;
      default:  pre = ~ubin;
    endcase
    word = pre & mask;
  end
endmodule

// File: rtl/oflt_top.sv
module oflt_top #(
  parameter int          IN_W     = 12,
  parameter int          OUT_W    = 16,
  parameter int          FRAC     = 4,
  parameter int          HEAD     = 2,
  parameter int          NARROW_W = 8,
  parameter logic [15:0] LIM_FULL = 16'h7FF0,
  parameter logic [15:0] LIM_HALF = 16'h3FF8,
  localparam int         ACC_W    = OUT_W + FRAC + HEAD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [ACC_W-1:0] res,
  input  logic [2:0]       rnd,
  input  logic             narrow,
  input  logic             uns_io,
  input  logic             tco,
  input  logic             half_gain,
  input  logic             oe_n,
  input  logic [IN_W-1:0]  din,
  output logic [IN_W-1:0]  din_tc,
  output logic [OUT_W-1:0] dout,
  output logic [OUT_W-1:0] drv_en
);
  import oflt_pkg::*;

  localparam int DROP_W = $clog2(OUT_W) + 1;
  localparam int RV_W   = ACC_W - FRAC + 1;

  logic                    rs_meta, rs_q;
  logic [DROP_W-1:0]       drop;
  logic [OUT_W-1:0]        mask_d, mask_q;
  logic signed [RV_W-1:0]  rval;
  logic signed [OUT_W-1:0] lim;
  logic [OUT_W-1:0]        word_d, dout_q;
  fmt_e                    fmt;
  logic                    in_uns;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_q    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_q    <= rs_meta;
    end
  end

  // input word conversion to two's complement
  always_comb begin
    in_uns = uns_io && (rnd != '0);
    din_tc = din;
    if (in_uns) din_tc[IN_W-1] = ~din[IN_W-1];
  end

  assign fmt = pick_fmt(tco, uns_io, rnd);

  oflt_width_dec #(.OUT_W(OUT_W), .NARROW_W(NARROW_W), .DROP_W(DROP_W)) u_wdec (
    .rnd(rnd), .narrow(narrow), .drop(drop), .mask(mask_d)
  );

  oflt_round #(.ACC_W(ACC_W), .FRAC(FRAC), .DROP_W(DROP_W)) u_round (
    .res($signed(res)), .half_gain(half_gain), .drop(drop), .rval(rval)
  );

  oflt_limit #(.RV_W(RV_W), .OUT_W(OUT_W), .LIM_FULL(LIM_FULL),
               .LIM_HALF(LIM_HALF)) u_limit (
    .rval(rval), .half_gain(half_gain), .lim(lim)
  );

  oflt_format #(.OUT_W(OUT_W)) u_fmt (
    .lim(lim), .fmt(fmt), .half_gain(half_gain), .mask(mask_d), .word(word_d)
  );

  // output register with explicit load enable
  logic [OUT_W-1:0] dout_n, mask_n;
  always_comb begin
    dout_n = dout_q;
    mask_n = mask_q;
    if (ld_en) begin
      dout_n = word_d;
      mask_n = mask_d;
    end
  end

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      dout_q <= '0;
      mask_q <= '0;
    end else begin
      dout_q <= dout_n;
      mask_q <= mask_n;
    end
  end

  assign dout   = dout_q;
  assign drv_en = oe_n ? '0 : mask_q;

  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rs_q)
    $onehot0(~mask_q + OUT_W'(1)));                                    // R1
  AST_RELEASED_ZERO: assert property (@(posedge clk) disable iff (!rs_q)
    (dout_q & ~mask_q) == '0);                                         // R1
  AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rs_q)
    (!half_gain) |-> ($signed(lim) <= $signed({1'b0, LIM_FULL[14:0]}) &&
                      $signed(lim) >= -$signed({1'b0, LIM_FULL[14:0]}))); // R4
  AST_HALF_SIGN: assert property (@(posedge clk) disable iff (!rs_q)
    half_gain |-> (lim[OUT_W-1] == lim[OUT_W-2]));                     // R5
  AST_OE_DISABLE: assert property (@(posedge clk) disable iff (!rs_q)
    oe_n |-> (drv_en == '0));                                          // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rs_q)
    !ld_en |=> ($stable(dout_q) && $stable(mask_q)));                  // R8
endmodule

// File: tb/oflt_top_tb.sv
module oflt_top_tb;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n, ld_en, narrow, uns_io, tco, half_gain, oe_n;
  logic [21:0] res;
  logic [2:0]  rnd;
  logic [11:0] din, din_tc;
  logic [15:0] dout, drv_en;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [15:0] d;
    logic [15:0] e;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(PER/2) clk = ~clk;

  oflt_top u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .res(res), .rnd(rnd),
    .narrow(narrow), .uns_io(uns_io), .tco(tco), .half_gain(half_gain),
    .oe_n(oe_n), .din(din), .din_tc(din_tc), .dout(dout), .drv_en(drv_en)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int kept_drop(logic [2:0] c, logic nw);
    return (c == 3'd4 && nw) ? 8 : int'(c);
  endfunction

  function automatic logic [15:0] model(int r, logic [2:0] c, logic nw,
                                        logic u, logic t, logic h);
    longint v, lmt, q;
    int k;
    logic [15:0] w, ub, msk;
    v   = h ? longint'(r >>> 1) : longint'(r);
    k   = kept_drop(c, nw);
    q   = (v + (longint'(1) << (4 + k - 1))) >>> (4 + k);
    q   = q <<< k;
    lmt = h ? 64'h3FF8 : 64'h7FF0;
    if (q > lmt)  q = lmt;
    if (q < -lmt) q = -lmt;
    w   = q[15:0];
    ub  = w + (h ? 16'h4000 : 16'h8000);
    msk = 16'hFFFF << k;
    if (t)                 return w & msk;
    else if (u && c != 0)  return ub & msk;
    else                   return ~ub & msk;
  endfunction

  task automatic push(string tag, int r, logic [2:0] c, logic nw, logic u,
                      logic t, logic h, logic oe);
    exp_t it;
    @(negedge clk);
    res = r[21:0]; rnd = c; narrow = nw; uns_io = u; tco = t;
    half_gain = h; oe_n = oe; ld_en = 1'b1;
    it.d   = model(r, c, nw, u, t, h);
    it.e   = oe ? 16'h0000 : (16'hFFFF << kept_drop(c, nw));
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: an item loaded at this edge is compared a quarter period later
  always @(posedge clk) begin
    logic took;
    took = ld_en && rst_n;
    #(PER/4);
    if (took && sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      check({it.tag, " dout"}, dout, it.d);
      check({it.tag, " drv_en"}, drv_en, it.e);
    end
  end

  initial begin
    #(PER * 5000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; res = '0; rnd = '0; narrow = 1'b0;
    uns_io = 1'b0; tco = 1'b1; half_gain = 1'b0; oe_n = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    check("R10 reset dout", dout, 16'h0000);
    check("R10 reset drv_en", drv_en, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after release dout", dout, 16'h0000);

    push("R3 tie rounds up 16b",    (32'h1234 << 4) + 8, 3'd0, 0, 0, 1, 0, 0);
    push("R3 below half 16b",       (32'h1234 << 4) + 7, 3'd0, 0, 0, 1, 0, 0);
    push("R3 tie at 14b",            32'h1232 << 4,      3'd2, 0, 0, 1, 0, 0);
    push("R1 9b negative",         -(32'h1234 << 4),     3'd7, 0, 0, 1, 0, 0);
    push("R1 12b width",             32'h0ABC << 4,      3'd4, 0, 0, 1, 0, 0);
    push("R2 narrow 8b",             32'h2380 << 4,      3'd4, 1, 0, 1, 0, 0);
    push("R2 narrow ignored code3",  32'h2388 << 4,      3'd3, 1, 0, 1, 0, 0);
    push("R4 pos overflow",          32'h9000 << 4,      3'd0, 0, 0, 1, 0, 0);
    push("R4 neg overflow",        -(32'h9000 << 4),     3'd0, 0, 0, 1, 0, 0);
    push("R4 round then clip",      (32'h7FF0 << 4) + 8, 3'd0, 0, 0, 1, 0, 0);
    push("R4 limit at 8b",           32'h7FFF << 4,      3'd4, 1, 0, 1, 0, 0);
    push("R5 half pos clip",         32'h9000 << 4,      3'd0, 0, 0, 1, 1, 0);
    push("R5 half neg clip",       -(32'h9000 << 4),     3'd0, 0, 0, 1, 1, 0);
    push("R5 half scale",            32'h2000 << 4,      3'd1, 0, 0, 1, 1, 0);
    push("R6 unsigned zero",         0,                  3'd4, 0, 1, 0, 0, 0);
    push("R6 code0 forces inverted", 0,                  3'd0, 0, 1, 0, 0, 0);
    push("R6 inverted 15b",          32'h0100 << 4,      3'd1, 0, 0, 0, 0, 0);
    push("R6 half unsigned",         0,                  3'd1, 0, 1, 0, 1, 0);
    push("R6 unsigned negative",   -(32'h0800 << 4),     3'd5, 0, 1, 0, 0, 0);
    push("R7 oe high at load",       32'h0555 << 4,      3'd0, 0, 0, 1, 0, 1);
    @(negedge clk);
    ld_en = 1'b0;
    repeat (2) @(negedge clk);

    // R7: enables follow oe_n between edges, data unchanged
    oe_n = 1'b0;
    #1;
    check("R7 oe low restores", drv_en, 16'hFFFF);
    #(PER/4);
    oe_n = 1'b1;
    #1;
    check("R7 async disable", drv_en, 16'h0000);
    check("R7 dout untouched", dout, model(32'h0555 << 4, 3'd0, 0, 0, 1, 0));
    oe_n = 1'b0;

    // R8: hold while ld_en low
    @(negedge clk);
    res = 22'(32'h0123 << 4); rnd = 3'd6;
    repeat (3) @(negedge clk);
    check("R8 hold dout", dout, model(32'h0555 << 4, 3'd0, 0, 0, 1, 0));
    check("R8 hold drv_en", drv_en, 16'hFFFF);

    // R9: input conversion, no register
    din = 12'h800; uns_io = 1'b1; rnd = 3'd2; #1;
    check("R9 unsigned to tc", {4'h0, din_tc}, 16'h0000);
    din = 12'h3A5; #1;
    check("R9 msb set", {4'h0, din_tc}, 16'h0BA5);
    rnd = 3'd0; #1;
    check("R9 code0 passes", {4'h0, din_tc}, 16'h03A5);
    uns_io = 1'b0; rnd = 3'd3; din = 12'hF00; #1;
    check("R9 signed passes", {4'h0, din_tc}, 16'h0F00);

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R8 scoreboard: actual %0d left expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule